// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one column command into the column address of every data beat that follows it, one beat per clock. The memory controller presents a starting column together with a one-cycle start pulse. From the next cycle on, the generator drives the column for each beat and flags the final beat. The number of beats and the ordering come from a small mode register that software-visible logic elsewhere loads through a write strobe. A burst takes its mode from that register at the start pulse and keeps it until the burst ends.

Two beat orderings are available. In sequential ordering the low bits of the column count upward and wrap inside the aligned block of burst size. In interleaved ordering the low bits of the start column are XORed with the beat index. The column bits above the burst block never change during a burst. A burst can be cut short by a stop input: the beat shown while stop is high becomes the last one. A new start pulse in any cycle restarts the sequence from the new column.

The control is a two-state machine. In `ST_IDLE` no column is valid. The start transition (start pulse) moves to `ST_BURST`. In `ST_BURST` a column is valid each cycle. It leaves through the end transition (final beat reached or stop asserted, with no start) back to `ST_IDLE`. Its restart transition (start pulse while busy) stays in `ST_BURST` and sets the beat index to zero.

Top module: `burst_col_gen`

## Requirements
- R1: After reset `col_valid` and `last_beat` are 0, and the mode register holds a burst of 1 beat in sequential ordering.
- R2: The cycle after `cmd_start` is sampled high, `col_valid` is 1 and `col_out` equals the `cmd_col` sampled with it.
- R3: The length code selects the burst length as 1 << code: 0 gives 1 beat, 1 gives 2 beats, 2 gives 4 beats and 3 gives 8 beats, shown in consecutive cycles.
- R4: With `cfg_interleave` = 0 (sequential), beat i has low log2(BL) column bits equal to (start low bits + i) mod BL, and the upper column bits stay equal to those of the start column.
- R5: With `cfg_interleave` = 1 (interleaved), beat i has low log2(BL) column bits equal to the start low bits XOR i, and the upper column bits unchanged.
- R6: `last_beat` is 1 only while `col_valid` is 1, on beat BL-1. With no new start, `col_valid` is 0 in the next cycle.
- R7: If `burst_stop` is high during a valid beat, `last_beat` is 1 in that same cycle and `col_valid` is 0 from the next cycle, unless a start is also present.
- R8: A `cmd_start` during a burst takes priority over `burst_stop` and over the end of the burst: the next cycle shows beat 0 of the new column.
- R9: A mode write (`cfg_we`) during a burst does not change the length or ordering of that burst. The next burst started after the write uses the new mode.
- R10: `burst_stop` while idle has no effect: `col_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Loads the mode register |
| cfg_len_code | input | CODE_W | Length code, burst = 1 << code |
| cfg_interleave | input | 1 | 1 selects interleaved ordering, 0 sequential |
| cmd_start | input | 1 | Column command pulse, starts or restarts a burst |
| cmd_col | input | COL_W | Start column of the burst |
| burst_stop | input | 1 | Ends the burst after the current beat |
| col_valid | output | 1 | A beat column is being driven |
| col_out | output | COL_W | Column of the current beat |
| last_beat | output | 1 | Current beat is the final one |

## Verification
Sequential and interleaved bursts are run from start columns whose low bits are not zero, so that wrap-around within the block and the XOR pattern produce different columns. Each length code is run from the same start column to show the beat count and the wrap size. Stops in mid-burst, a restart that coincides with a stop, and a stop while idle separate the priority rules. A mode write in mid-burst shows that the mode is captured at the start pulse and not read on every beat.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } gen_state_t;

endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg #(
    parameter int CODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CODE_W-1:0] cfg_len_code,
    input  logic              cfg_interleave,
    output logic [CODE_W-1:0] mode_len_code,
    output logic              mode_interleave
);

    // Holds the programmed length and ordering until the next write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_len_code   <= '0;
            mode_interleave <= 1'b0;
        end else if (cfg_we) begin
            mode_len_code   <= cfg_len_code;
            mode_interleave <= cfg_interleave;
        end
    end

endmodule

// File: rtl/burst_beat_fsm.sv
module burst_beat_fsm
    import burst_col_pkg::*;
#(
    parameter int COL_W  = 11,
    parameter int BEAT_W = 3,
    parameter int CODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic              burst_stop,
    input  logic [CODE_W-1:0] mode_len_code,
    input  logic              mode_interleave,
    output logic              busy,
    output logic              final_beat,
    output logic [BEAT_W-1:0] beat_idx,
    output logic [BEAT_W-1:0] beat_mask,
    output logic [COL_W-1:0]  base_col,
    output logic              ord_interleave
);

    gen_state_t        state_q, state_d;
    logic [BEAT_W-1:0] mask_new;
    logic              at_end;

    // Mask of the low column bits that move within a burst
    always_comb begin
        for (int i = 0; i < BEAT_W; i++) begin
            mask_new[i] = (i < int'(mode_len_code));
        end
    end

    assign at_end = (beat_idx == beat_mask) || burst_stop;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_start) state_d = ST_BURST;
            end
            ST_BURST: begin
                if (cmd_start)   state_d = ST_BURST;
                else if (at_end) state_d = ST_IDLE;
                else             state_d = ST_BURST;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Burst context: captured at start, beat index advanced each cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_idx       <= '0;
            beat_mask      <= '0;
            base_col       <= '0;
            ord_interleave <= 1'b0;
        end else if (cmd_start) begin
            beat_idx       <= '0;
            beat_mask      <= mask_new;
            base_col       <= cmd_col;
            ord_interleave <= mode_interleave;
        end else if (state_q == ST_BURST && !at_end) begin
            beat_idx <= beat_idx + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        busy       = (state_q == ST_BURST);
        final_beat = (state_q == ST_BURST) && at_end;
    end

endmodule

// File: rtl/burst_col_map.sv
module burst_col_map #(
    parameter int COL_W  = 11,
    parameter int BEAT_W = 3
) (
    input  logic [COL_W-1:0]  base_col,
    input  logic [BEAT_W-1:0] beat_idx,
    input  logic [BEAT_W-1:0] beat_mask,
    input  logic              ord_interleave,
    output logic [COL_W-1:0]  col_out
);

    logic [BEAT_W-1:0] start_low, seq_low, xor_low, low_out;

    assign start_low = base_col[BEAT_W-1:0];
    assign seq_low   = start_low + beat_idx;
    assign xor_low   = start_low ^ beat_idx;

    // Bits inside the burst block follow the ordering, the rest hold
    for (genvar b = 0; b < BEAT_W; b++) begin : g_low
        assign low_out[b] = beat_mask[b] ? (ord_interleave ? xor_low[b] : seq_low[b])
                                         : start_low[b];
    end

    assign col_out = {base_col[COL_W-1:BEAT_W], low_out};

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
    parameter int COL_W  = 11,
    parameter int BEAT_W = 3,
    localparam int CODE_W = $clog2(BEAT_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CODE_W-1:0] cfg_len_code,
    input  logic              cfg_interleave,
    input  logic              cmd_start,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic              burst_stop,
    output logic              col_valid,
    output logic [COL_W-1:0]  col_out,
    output logic              last_beat
);

    logic [CODE_W-1:0] mode_len_code;
    logic              mode_interleave;
    logic [BEAT_W-1:0] beat_idx, beat_mask;
    logic [COL_W-1:0]  base_col;
    logic              ord_interleave;

    burst_mode_reg #(.CODE_W(CODE_W)) u_mode (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_we          (cfg_we),
        .cfg_len_code    (cfg_len_code),
        .cfg_interleave  (cfg_interleave),
        .mode_len_code   (mode_len_code),
        .mode_interleave (mode_interleave)
    );

    burst_beat_fsm #(.COL_W(COL_W), .BEAT_W(BEAT_W), .CODE_W(CODE_W)) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .cmd_start       (cmd_start),
        .cmd_col         (cmd_col),
        .burst_stop      (burst_stop),
        .mode_len_code   (mode_len_code),
        .mode_interleave (mode_interleave),
        .busy            (col_valid),
        .final_beat      (last_beat),
        .beat_idx        (beat_idx),
        .beat_mask       (beat_mask),
        .base_col        (base_col),
        .ord_interleave  (ord_interleave)
    );

    burst_col_map #(.COL_W(COL_W), .BEAT_W(BEAT_W)) u_map (
        .base_col       (base_col),
        .beat_idx       (beat_idx),
        .beat_mask      (beat_mask),
        .ord_interleave (ord_interleave),
        .col_out        (col_out)
    );

endmodule

// File: rtl/burst_col_gen_checker.sv
module burst_col_gen_checker #(
    parameter int COL_W  = 11,
    parameter int BEAT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_start,
    input logic [COL_W-1:0] cmd_col,
    input logic             burst_stop,
    input logic             col_valid,
    input logic [COL_W-1:0] col_out,
    input logic             last_beat
);

    p_first_col_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> (col_valid && col_out == $past(cmd_col)));

    p_upper_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && !cmd_start) |=>
            (!col_valid || col_out[COL_W-1:BEAT_W] == $past(col_out[COL_W-1:BEAT_W])));

    p_last_in_burst_r6: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |-> col_valid);

    p_end_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (last_beat && !cmd_start) |=> !col_valid);

    p_stop_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_stop && col_valid) |-> last_beat);

    p_restart_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && cmd_start && burst_stop) |=> col_valid);

    p_idle_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!col_valid && burst_stop && !cmd_start) |=> !col_valid);

endmodule

bind burst_col_gen burst_col_gen_checker #(.COL_W(COL_W), .BEAT_W(BEAT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_start  (cmd_start),
    .cmd_col    (cmd_col),
    .burst_stop (burst_stop),
    .col_valid  (col_valid),
    .col_out    (col_out),
    .last_beat  (last_beat)
);

// File: tb/burst_col_gen_bench.sv
module burst_col_gen_bench;

    localparam int CLK_PERIOD = 10;
    localparam int COL_W      = 11;
    localparam int BEAT_W     = 3;
    localparam int CODE_W     = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [CODE_W-1:0] cfg_len_code = '0;
    logic              cfg_interleave = 1'b0;
    logic              cmd_start = 1'b0;
    logic [COL_W-1:0]  cmd_col = '0;
    logic              burst_stop = 1'b0;
    logic              col_valid;
    logic [COL_W-1:0]  col_out;
    logic              last_beat;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_col_gen #(.COL_W(COL_W), .BEAT_W(BEAT_W)) u_burst_col_gen (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_we         (cfg_we),
        .cfg_len_code   (cfg_len_code),
        .cfg_interleave (cfg_interleave),
        .cmd_start      (cmd_start),
        .cmd_col        (cmd_col),
        .burst_stop     (burst_stop),
        .col_valid      (col_valid),
        .col_out        (col_out),
        .last_beat      (last_beat)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected column: base of the aligned block plus the ordered offset
    function automatic int exp_col(int start, int beat, int len, bit il);
        int base, off;
        base = start - (start % len);
        off  = il ? ((start % len) ^ beat) : (((start % len) + beat) % len);
        return base + off;
    endfunction

    task automatic set_mode(int code, bit il);
        @(negedge clk);
        cfg_we = 1'b1; cfg_len_code = CODE_W'(code); cfg_interleave = il;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // One burst; stop_at < 0 means run to the natural end
    task automatic run_burst(string tag, int col, int code, bit il, int stop_at);
        int len, nb;
        len = 1 << code;
        nb  = (stop_at >= 0 && stop_at < len) ? stop_at + 1 : len;
        @(negedge clk);
        cmd_start = 1'b1; cmd_col = COL_W'(col);
        for (int i = 0; i < nb; i++) begin
            @(negedge clk);
            cmd_start  = 1'b0;
            burst_stop = (i == stop_at);
            #1;
            chk(tag, int'(col_valid), 1);
            chk(tag, int'(col_out), exp_col(col, i, len, il));
            chk(tag, int'(last_beat), int'(i == nb - 1));
        end
        @(negedge clk);
        burst_stop = 1'b0;
        #1;
        chk(tag, int'(col_valid), 0);
    endtask

    task automatic t_reset();
        chk("R1", int'(col_valid), 0);
        chk("R1", int'(last_beat), 0);
        run_burst("R1", 'h2B5, 0, 1'b0, -1);
    endtask

    task automatic t_lengths();
        for (int c = 0; c < 4; c++) begin
            set_mode(c, 1'b0);
            run_burst("R3", 'h123, c, 1'b0, -1);
        end
    endtask

    task automatic t_sequential();
        set_mode(3, 1'b0);
        run_burst("R4", 'h2F5, 3, 1'b0, -1);
        set_mode(2, 1'b0);
        run_burst("R4", 'h40E, 2, 1'b0, -1);
        run_burst("R2", 'h7FF, 2, 1'b0, -1);
    endtask

    task automatic t_interleave();
        set_mode(3, 1'b1);
        run_burst("R5", 'h1A3, 3, 1'b1, -1);
        set_mode(2, 1'b1);
        run_burst("R5", 'h006, 2, 1'b1, -1);
        set_mode(1, 1'b1);
        run_burst("R6", 'h331, 1, 1'b1, -1);
    endtask

    task automatic t_stop();
        set_mode(3, 1'b0);
        run_burst("R7", 'h0C6, 3, 1'b0, 2);
        run_burst("R7", 'h0C6, 3, 1'b0, 0);
    endtask

    task automatic t_restart();
        int seq2 [4] = '{'h45, 'h46, 'h47, 'h44};
        set_mode(2, 1'b0);
        @(negedge clk);
        cmd_start = 1'b1; cmd_col = 'h010;
        @(negedge clk);
        cmd_start = 1'b0;
        #1;
        chk("R8", int'(col_out), 'h010);
        @(negedge clk);
        cmd_start = 1'b1; cmd_col = 'h045; burst_stop = 1'b1;
        #1;
        chk("R8", int'(col_out), 'h011);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            cmd_start = 1'b0; burst_stop = 1'b0;
            #1;
            chk("R8", int'(col_valid), 1);
            chk("R8", int'(col_out), seq2[i]);
            chk("R8", int'(last_beat), int'(i == 3));
        end
        @(negedge clk);
        #1;
        chk("R8", int'(col_valid), 0);
    endtask

    task automatic t_cfg_mid();
        set_mode(3, 1'b0);
        @(negedge clk);
        cmd_start = 1'b1; cmd_col = 'h008;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            cmd_start = 1'b0;
            cfg_we = (i == 2);
            cfg_len_code = 2'd1; cfg_interleave = 1'b1;
            #1;
            chk("R9", int'(col_valid), 1);
            chk("R9", int'(col_out), 'h008 + i);
        end
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
        chk("R9", int'(col_valid), 0);
        run_burst("R9", 'h00B, 1, 1'b1, -1);
    endtask

    task automatic t_idle_stop();
        @(negedge clk);
        burst_stop = 1'b1;
        @(negedge clk);
        burst_stop = 1'b0;
        #1;
        chk("R10", int'(col_valid), 0);
        chk("R10", int'(last_beat), 0);
        set_mode(2, 1'b1);
        run_burst("R10", 'h155, 2, 1'b1, -1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset_pre: begin
            chk("R1", int'(col_valid), 0);
        end
        rst_n = 1'b1;
        t_reset();
        t_lengths();
        t_sequential();
        t_interleave();
        t_stop();
        t_restart();
        t_cfg_mid();
        t_idle_stop();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule